// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Front End

This block is the fetch front end of a fine-grained multithreaded core. It holds one program counter per hardware thread. Each cycle a round-robin arbiter picks one thread from an eligible mask supplied by an external thread controller, so a different thread can issue on every clock. The chosen thread's PC addresses a set-associative instruction cache. The per-way tag and valid arrays are read in a first stage. Tags are compared in a second stage, which reports either a qualified fetch (thread, PC and per-way hit vector) or a miss (thread and line address).

Program counters move by a fixed priority: a host job, then a rollback, then a rewind after a miss, then the normal step past a scheduled fetch. Refills arrive on a single-cycle write port that names the victim way, chosen by an external replacement policy. A refill to the set that is being read in the same cycle is forwarded straight into the stage-two registers.

The outputs are plain valid-qualified pulses with no back-pressure. A consumer takes every cycle in which `fetch_valid_o` or `miss_o` is high. The only way to hold a thread back is to drop it from `eligible_i`, which takes effect on the next arbitration.

Top module: `ifetch_front`

## Requirements
- R1: Each cycle, at most one thread is granted: the first set bit of `eligible_i` found by searching upward (with wrap) from the thread after the last one granted, starting at thread 0 after reset. The granted thread and the PC it held appear on the stage-two outputs in the next cycle.
- R2: A job (`job_valid_i`) for a thread loads `job_pc_i` into that thread's PC at the clock edge, overriding every other update.
- R3: A rollback for a thread (`rollback_valid_i[t]`, with the PC in bits `[t*ADDR_W +: ADDR_W]` of `rollback_pc_i`) loads that PC unless a job for the same thread is present.
- R4: When the stage-two lookup of a thread finds no hit (instruction valid), that thread's PC is decreased by 4 unless a job or rollback targets it.
- R5: A thread granted in a cycle, with no higher-priority update, has its PC increased by 4.
- R6: Bit w of `hit_way_o` is high only when way w's line is valid and its stored tag equals the tag of the stage-two PC. The address splits as tag, a log2(SETS)-bit set index, and a 2-bit byte offset.
- R7: A refill writes the tag and sets the valid bit of way `refill_way_i` at the set index of `refill_line_i` (line address = PC bits above the offset). Later lookups of that line in that way hit.
- R8: If a refill lands on the set being read in the same cycle, the stage-two valid bit and tag of the victim way take the refilled values (cut-through).
- R9: `miss_o` is high only when the stage-two instruction is valid, no rollback is active for its thread, and no way hits. `miss_thread_o` and `miss_line_o` then give the thread and its PC line address.
- R10: `fetch_valid_o` is high only when the stage-two instruction is valid, no rollback is active for its thread, and some way hits. `miss_o` and `fetch_valid_o` are never high together.
- R11: After reset every PC is 0, all lines are invalid, and neither `fetch_valid_o` nor `miss_o` is high until a thread has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eligible_i | input | THREADS | Threads allowed to fetch this cycle |
| job_valid_i | input | 1 | Host job start strobe |
| job_thread_i | input | TID_W | Thread receiving the job |
| job_pc_i | input | ADDR_W | Start PC of the job |
| rollback_valid_i | input | THREADS | Per-thread rollback request |
| rollback_pc_i | input | THREADS*ADDR_W | Per-thread restore PC, thread t in slice t |
| refill_valid_i | input | 1 | Refill write strobe |
| refill_line_i | input | ADDR_W-2 | Line address being filled |
| refill_way_i | input | WAY_W | Victim way to fill |
| fetch_valid_o | output | 1 | Qualified hit for the stage-two thread |
| fetch_thread_o | output | TID_W | Stage-two thread |
| fetch_pc_o | output | ADDR_W | Stage-two PC |
| hit_way_o | output | WAYS | Per-way hit vector of the stage-two lookup |
| miss_o | output | 1 | Qualified miss for the stage-two thread |
| miss_thread_o | output | TID_W | Thread that missed |
| miss_line_o | output | ADDR_W-2 | Line address that missed |

## Verification
A grant made in cycle t is reported on the outputs in cycle t+1. A PC update from a job, rollback, rewind or step takes effect at the edge that closes its cycle, so the new PC is seen at the next grant of that thread. Refills are seen by lookups selected after the write edge, or in the same cycle through cut-through. The bench drives inputs just after the falling edge and compares outputs 1 ns later against a model that has already applied every earlier edge. It then advances the model by exactly one edge, so every expected value is aligned with the register delay that produces it.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned OFF_W      = 2;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_JOB,
    PC_ROLLBACK,
    PC_REWIND,
    PC_STEP
  } pc_cause_e;
endpackage

// File: rtl/ifetch_rr_arb.sv
module ifetch_rr_arb #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_id,
  output logic          grant_any
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int c;
    grant     = '0;
    grant_id  = '0;
    grant_any = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      c = (int'(ptr_q) + k) % int'(N);
      if (!grant_any && req[IW'(c)]) begin
        grant_any = 1'b1;
        grant_id  = IW'(c);
      end
    end
    if (grant_any) grant[grant_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (grant_any) begin
      if (grant_id == IW'(N - 1)) ptr_q <= '0;
      else                        ptr_q <= grant_id + IW'(1);
    end
  end
endmodule

// File: rtl/ifetch_pc_bank.sv
module ifetch_pc_bank
  import ifetch_pkg::*;
#(
  parameter int unsigned THREADS = 4,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             job_valid,
  input  logic [TID_W-1:0]                 job_tid,
  input  logic [ADDR_W-1:0]                job_pc,
  input  logic [THREADS-1:0]               rb_valid,
  input  logic [THREADS-1:0][ADDR_W-1:0]   rb_pc,
  input  logic                             rewind_valid,
  input  logic [TID_W-1:0]                 rewind_tid,
  input  logic [THREADS-1:0]               sched,
  output logic [THREADS-1:0][ADDR_W-1:0]   pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    pc_cause_e         cause;
    logic [ADDR_W-1:0] pc_q;

    always_comb begin
      if (job_valid && job_tid == TID_W'(t))               cause = PC_JOB;
      else if (rb_valid[t])                                cause = PC_ROLLBACK;
      else if (rewind_valid && rewind_tid == TID_W'(t))    cause = PC_REWIND;
      else if (sched[t])                                   cause = PC_STEP;
      else                                                 cause = PC_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q <= '0;
      end else begin
        case (cause)
          PC_JOB:      pc_q <= job_pc;
          PC_ROLLBACK: pc_q <= rb_pc[t];
          PC_REWIND:   pc_q <= pc_q - STEP;
          PC_STEP:     pc_q <= pc_q + STEP;
          default:     pc_q <= pc_q;
        endcase
      end
    end

    assign pc[t] = pc_q;
  end
endmodule

// File: rtl/ifetch_tag_ways.sv
module ifetch_tag_ways #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 32,
  parameter int unsigned TAG_W = 25,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic                         fill_en,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [TAG_W-1:0]             fill_tag,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0]              rd_lv,
  output logic [WAYS-1:0]              rd_fwd
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    logic [SETS-1:0]  vbits;
    logic [TAG_W-1:0] tag_q;
    logic             lv_q;
    logic             fwd_q;
    logic             wr;
    logic             bypass;

    assign wr     = fill_en && (fill_way == WAY_W'(w));
    assign bypass = wr && (fill_idx == rd_idx);

    always_ff @(posedge clk) begin
      if (wr) mem[fill_idx] <= fill_tag;
      if (bypass) tag_q <= fill_tag;
      else        tag_q <= mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vbits <= '0;
        lv_q  <= 1'b0;
        fwd_q <= 1'b0;
      end else begin
        if (wr) vbits[fill_idx] <= 1'b1;
        lv_q  <= bypass ? 1'b1 : (vbits[rd_idx] & rd_en);
        fwd_q <= bypass;
      end
    end

    assign rd_tag[w] = tag_q;
    assign rd_lv[w]  = lv_q;
    assign rd_fwd[w] = fwd_q;
  end
endmodule

// File: rtl/ifetch_front.sv
module ifetch_front
  import ifetch_pkg::*;
#(
  parameter int unsigned THREADS = 4,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned SETS    = 32,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned LINE_W = ADDR_W - OFF_W,
  localparam int unsigned TAG_W  = LINE_W - IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [THREADS-1:0]          eligible_i,
  input  logic                        job_valid_i,
  input  logic [TID_W-1:0]            job_thread_i,
  input  logic [ADDR_W-1:0]           job_pc_i,
  input  logic [THREADS-1:0]          rollback_valid_i,
  input  logic [THREADS*ADDR_W-1:0]   rollback_pc_i,
  input  logic                        refill_valid_i,
  input  logic [LINE_W-1:0]           refill_line_i,
  input  logic [WAY_W-1:0]            refill_way_i,
  output logic                        fetch_valid_o,
  output logic [TID_W-1:0]            fetch_thread_o,
  output logic [ADDR_W-1:0]           fetch_pc_o,
  output logic [WAYS-1:0]             hit_way_o,
  output logic                        miss_o,
  output logic [TID_W-1:0]            miss_thread_o,
  output logic [LINE_W-1:0]           miss_line_o
);
  // stage one: arbitration and array read
  logic [THREADS-1:0]              grant_vec;
  logic [TID_W-1:0]                grant_id;
  logic                            grant_any;
  logic [THREADS-1:0][ADDR_W-1:0]  pc_all;
  logic [THREADS-1:0][ADDR_W-1:0]  rb_pc;
  logic [ADDR_W-1:0]               sel_pc;
  logic [IDX_W-1:0]                sel_idx;

  // stage two registers and results
  logic                            s2_valid;
  logic [TID_W-1:0]                s2_thread;
  logic [ADDR_W-1:0]               s2_pc;
  logic [WAYS-1:0][TAG_W-1:0]      way_tag;
  logic [WAYS-1:0]                 way_lv;
  logic [WAYS-1:0]                 way_fwd;
  logic [WAYS-1:0]                 hit_vec;
  logic                            any_hit;
  logic                            raw_miss;
  logic                            rb_now;

  assign rb_pc   = rollback_pc_i;
  assign sel_pc  = pc_all[grant_id];
  assign sel_idx = sel_pc[OFF_W +: IDX_W];

  ifetch_rr_arb #(.N(THREADS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (eligible_i),
    .grant     (grant_vec),
    .grant_id  (grant_id),
    .grant_any (grant_any)
  );

  ifetch_pc_bank #(.THREADS(THREADS), .ADDR_W(ADDR_W)) u_pcs (
    .clk          (clk),
    .rst_n        (rst_n),
    .job_valid    (job_valid_i),
    .job_tid      (job_thread_i),
    .job_pc       (job_pc_i),
    .rb_valid     (rollback_valid_i),
    .rb_pc        (rb_pc),
    .rewind_valid (raw_miss),
    .rewind_tid   (s2_thread),
    .sched        (grant_vec),
    .pc           (pc_all)
  );

  ifetch_tag_ways #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (grant_any),
    .rd_idx   (sel_idx),
    .fill_en  (refill_valid_i),
    .fill_way (refill_way_i),
    .fill_idx (refill_line_i[IDX_W-1:0]),
    .fill_tag (refill_line_i[LINE_W-1:IDX_W]),
    .rd_tag   (way_tag),
    .rd_lv    (way_lv),
    .rd_fwd   (way_fwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_thread <= '0;
      s2_pc     <= '0;
    end else begin
      s2_valid  <= grant_any;
      s2_thread <= grant_id;
      s2_pc     <= sel_pc;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_lv[w] && (way_tag[w] == s2_pc[ADDR_W-1:OFF_W+IDX_W]);
  end

  assign any_hit  = |hit_vec;
  assign raw_miss = s2_valid && !any_hit;
  assign rb_now   = rollback_valid_i[s2_thread];

  assign fetch_valid_o  = s2_valid && !rb_now && any_hit;
  assign fetch_thread_o = s2_thread;
  assign fetch_pc_o     = s2_pc;
  assign hit_way_o      = hit_vec;
  assign miss_o         = raw_miss && !rb_now;
  assign miss_thread_o  = s2_thread;
  assign miss_line_o    = s2_pc[ADDR_W-1:OFF_W];

  logic unused_fwd;
  assign unused_fwd = |way_fwd;
endmodule

// File: rtl/ifetch_front_chk.sv
module ifetch_front_chk #(
  parameter int unsigned THREADS = 4,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned TID_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [THREADS-1:0] eligible_i,
  input logic [THREADS-1:0] rollback_valid_i,
  input logic [THREADS-1:0] grant_vec,
  input logic               fetch_valid_o,
  input logic [TID_W-1:0]   fetch_thread_o,
  input logic [WAYS-1:0]    hit_way_o,
  input logic               miss_o
);
  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~eligible_i) == '0);

  a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid_o && miss_o));

  a_r10_valid_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_o |-> (hit_way_o != '0));

  a_r9_miss_has_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> (hit_way_o == '0));

  a_r10_rollback_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_valid_i[fetch_thread_o] |-> !(fetch_valid_o || miss_o));

  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(fetch_valid_o || miss_o));
endmodule

bind ifetch_front ifetch_front_chk #(
  .THREADS(THREADS), .WAYS(WAYS), .TID_W(TID_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .eligible_i       (eligible_i),
  .rollback_valid_i (rollback_valid_i),
  .grant_vec        (grant_vec),
  .fetch_valid_o    (fetch_valid_o),
  .fetch_thread_o   (fetch_thread_o),
  .hit_way_o        (hit_way_o),
  .miss_o           (miss_o)
);

// File: tb/ifetch_front_bench.sv
module ifetch_front_bench;
  localparam int T  = 4;
  localparam int W  = 4;
  localparam int S  = 32;
  localparam int AW = 32;
  localparam int IW = 5;
  localparam int LW = AW - 2;
  localparam int TW = LW - IW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [T-1:0]    elig = '0;
  logic            jv = 1'b0;
  logic [1:0]      jt = '0;
  logic [AW-1:0]   jpc = '0;
  logic [T-1:0]    rbv = '0;
  logic [T*AW-1:0] rbpc = '0;
  logic            rfv = 1'b0;
  logic [LW-1:0]   rfline = '0;
  logic [1:0]      rfway = '0;

  logic            fvalid, miss;
  logic [1:0]      fthread, mthread;
  logic [AW-1:0]   fpc;
  logic [W-1:0]    hitw;
  logic [LW-1:0]   mline;

  ifetch_front u_ifetch_front (
    .clk(clk), .rst_n(rst_n), .eligible_i(elig),
    .job_valid_i(jv), .job_thread_i(jt), .job_pc_i(jpc),
    .rollback_valid_i(rbv), .rollback_pc_i(rbpc),
    .refill_valid_i(rfv), .refill_line_i(rfline), .refill_way_i(rfway),
    .fetch_valid_o(fvalid), .fetch_thread_o(fthread), .fetch_pc_o(fpc),
    .hit_way_o(hitw), .miss_o(miss), .miss_thread_o(mthread), .miss_line_o(mline)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [AW-1:0] m_pc [T];
  int            m_src [T];   // 0 reset,1 job,2 rollback,3 rewind,4 step
  int            m_ptr;
  logic          m_vb [W][S];
  logic [TW-1:0] m_tag [W][S];
  logic          s_v;
  int            s_t;
  logic [AW-1:0] s_pc;
  int            s_src;
  logic          s_lv [W];
  logic [TW-1:0] s_tag [W];
  logic          s_ct;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string pc_req(input int s);
    case (s)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    for (int t = 0; t < T; t++) begin m_pc[t] = '0; m_src[t] = 0; end
    for (int w = 0; w < W; w++) begin
      s_lv[w] = 1'b0; s_tag[w] = '0;
      for (int i = 0; i < S; i++) begin m_vb[w][i] = 1'b0; m_tag[w][i] = '0; end
    end
    m_ptr = 0; s_v = 1'b0; s_t = 0; s_pc = '0; s_src = 0; s_ct = 1'b0;
  endtask

  // compare outputs for the current cycle, then advance model by one edge
  task automatic step();
    logic [W-1:0] hv;
    logic any, rb_now, e_fv, e_miss;
    int g;
    logic [AW-1:0] n_pc;
    int n_t, idx, ridx;
    logic [TW-1:0] rtag;
    logic n_lv [W];
    logic [TW-1:0] n_tag [W];
    logic n_ct;
    #1;
    for (int w = 0; w < W; w++) hv[w] = s_lv[w] && (s_tag[w] == s_pc[AW-1:IW+2]);
    any    = |hv;
    rb_now = rbv[s_t];
    e_fv   = s_v && !rb_now && any;
    e_miss = s_v && !rb_now && !any;
    chk("R10", "fetch_valid", 64'(fvalid), 64'(e_fv));
    chk("R9", "miss", 64'(miss), 64'(e_miss));
    if (e_fv) begin
      chk("R1", "fetch_thread", 64'(fthread), 64'(s_t));
      chk(pc_req(s_src), "fetch_pc", 64'(fpc), 64'(s_pc));
      if (s_ct) chk("R8", "hit_way cut-through", 64'(hitw), 64'(hv));
      else      chk("R6 R7", "hit_way", 64'(hitw), 64'(hv));
    end
    if (e_miss) begin
      chk("R1", "miss_thread", 64'(mthread), 64'(s_t));
      chk("R9", "miss_line", 64'(mline), 64'(s_pc[AW-1:2]));
      chk(pc_req(s_src), "miss pc", 64'(fpc), 64'(s_pc));
    end
    // arbitration
    g = -1;
    for (int k = 0; k < T; k++) if (g < 0 && elig[(m_ptr + k) % T]) g = (m_ptr + k) % T;
    n_t  = (g >= 0) ? g : 0;
    n_pc = m_pc[n_t];
    idx  = int'(n_pc[IW+1:2]);
    ridx = int'(rfline[IW-1:0]);
    rtag = rfline[LW-1:IW];
    n_ct = 1'b0;
    for (int w = 0; w < W; w++) begin
      if (rfv && int'(rfway) == w && ridx == idx) begin
        n_lv[w] = 1'b1; n_tag[w] = rtag; n_ct = 1'b1;
      end else begin
        n_lv[w] = m_vb[w][idx] && (g >= 0); n_tag[w] = m_tag[w][idx];
      end
    end
    s_src = m_src[n_t];
    for (int t = 0; t < T; t++) begin
      if (jv && int'(jt) == t)          begin m_pc[t] = jpc; m_src[t] = 1; end
      else if (rbv[t])                  begin m_pc[t] = rbpc[t*AW +: AW]; m_src[t] = 2; end
      else if (s_v && !any && s_t == t) begin m_pc[t] = m_pc[t] - 4; m_src[t] = 3; end
      else if (g == t)                  begin m_pc[t] = m_pc[t] + 4; m_src[t] = 4; end
    end
    if (rfv) begin m_vb[rfway][ridx] = 1'b1; m_tag[rfway][ridx] = rtag; end
    if (g >= 0) m_ptr = (g + 1) % T;
    s_v = (g >= 0); s_t = n_t; s_pc = n_pc; s_ct = n_ct;
    for (int w = 0; w < W; w++) begin s_lv[w] = n_lv[w]; s_tag[w] = n_tag[w]; end
  endtask

  task automatic idle_inputs();
    elig = '0; jv = 1'b0; rbv = '0; rfv = 1'b0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: quiet after reset while nothing is eligible
    for (int i = 0; i < 2; i++) begin
      cycle(); idle_inputs();
      #1;
      chk("R11", "fetch_valid after reset", 64'(fvalid), 64'd0);
      chk("R11", "miss after reset", 64'(miss), 64'd0);
      #0 ; s_v = s_v;
    end
    // R11, R1, R4: all eligible from reset, every thread starts at 0 and misses
    for (int i = 0; i < 6; i++) begin
      cycle(); idle_inputs(); elig = 4'hF; step();
    end
    // R8: single thread, job then refill into the set being read
    cycle(); idle_inputs(); elig = 4'b0001; jv = 1'b1; jt = 2'd0; jpc = 32'h40; step();
    cycle(); idle_inputs(); elig = 4'b0001; rfv = 1'b1; rfline = 30'h10; rfway = 2'd2; step();
    cycle(); idle_inputs(); elig = 4'b0001; step();
    // R7: refill line 0x44 in way 1 ahead of its lookup, then hit it
    cycle(); idle_inputs(); elig = 4'b0000; rfv = 1'b1; rfline = 30'h11; rfway = 2'd1; step();
    for (int i = 0; i < 3; i++) begin cycle(); idle_inputs(); elig = 4'b0001; step(); end
    // R3 beats R4, R2 beats R3
    cycle(); idle_inputs(); elig = 4'b0010; step();
    cycle(); idle_inputs(); elig = 4'b0010; rbv = 4'b0010; rbpc[AW +: AW] = 32'h40; step();
    cycle(); idle_inputs(); elig = 4'b0010; rbv = 4'b0010; jv = 1'b1; jt = 2'd1; jpc = 32'h44; step();
    for (int i = 0; i < 3; i++) begin cycle(); idle_inputs(); elig = 4'b0010; step(); end
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      cycle(); idle_inputs();
      elig = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF & ~4'($urandom % 2);
      if ($urandom % 8 == 0) begin
        jv = 1'b1; jt = 2'($urandom); jpc = 32'(($urandom % 256) & ~32'd3);
      end
      for (int t = 0; t < T; t++) begin
        if ($urandom % 16 == 0) begin
          rbv[t] = 1'b1; rbpc[t*AW +: AW] = 32'(($urandom % 256) & ~32'd3);
        end
      end
      if ($urandom % 3 == 0) begin
        rfv = 1'b1; rfline = 30'($urandom % 64); rfway = 2'($urandom);
      end
      step();
    end
    cycle(); idle_inputs();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule